// File: doc/BRIEF.md
# Two-Phase Externally Fed 8-bit Processor Core

This block is a small 8-bit processor with no program store of its own. An outside controller places one 16-bit instruction on a parallel input bus and holds it there for two clock cycles. The core keeps an 8-bit program counter, eight 8-bit general registers and a 16-byte data memory. It reports everything on a single 8-bit output bus.

The core toggles between two phases. In the program-counter phase the output shows the current PC. In the execute phase the output shows the result of the instruction on the bus. All state changes happen on the edge that leaves the execute phase: register write, memory store and PC update. The controller reads the result in the execute phase and the new PC in the phase after it.

Instruction fields are fixed. The opcode sits in [15:12], rd in [11:9], rs1 in [8:6] and rs2 in [5:3]. An R-type function code sits in [2:0]. An immediate-form constant sits in [5:0], and a load-immediate byte in [7:0]. Stores and branches split their constant: bits [11:9] give the upper three bits and bits [2:0] the lower three. Every 6-bit constant is sign-extended to 8 bits.

Top module: `duophase_core`

## Requirements
- R1: Reset (synchronous, active-low `rst_n`) clears the PC to 0, all eight registers and all 16 memory bytes to 0, and the phase to the PC phase. After reset the output reads 0.
- R2: The phase toggles on every clock edge. In the execute phase the output is the instruction result. In the PC phase the output is the PC.
- R3: Opcode 0000 is register-register. The function code in [2:0] selects the operation: 000 add, 001 subtract, 010 and, 011 or, 100 xor, 101 shift left, 110 shift right (logical), 111 add. Shifts use the low 3 bits of rs2. The result is written to rd.
- R4: Opcodes 0001 add, 1000 and, 1001 or, 1010 xor, 1011 shift left and 1100 shift right combine rs1 with the sign-extended [5:0] constant. Shifts use the low 3 bits of that constant. The result is written to rd.
- R5: Opcode 0010 writes the byte [7:0] into rd. This byte is also the result.
- R6: Opcode 0100 stores rs2 at rs1 plus the split constant, and its result is the stored value. Opcode 0011 loads into rd from rs1 plus the [5:0] constant, and its result is the loaded byte. Only the low 4 address bits select the byte, so 0x08, 0x18 and 0xF8 all select entry 8.
- R7: Opcode 0101 branches when rs1 equals rs2. Opcode 0110 branches when they differ. Opcode 0111 branches when rs1 is less than rs2, both taken as signed. A taken branch sets the PC to the PC plus the sign-extended split constant, modulo 256. A branch that is not taken adds 1. The result of any branch is the PC that will be committed.
- R8: Every instruction other than those in R9 that is not a taken branch adds 1 to the PC. The PC changes only on the edge that leaves the execute phase.
- R9: Opcodes 1101, 1110 and 1111 change no register, memory byte or PC. Their result is the current PC.
- R10: Register r0 is an ordinary register that can be written and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr | input | 16 | Instruction, held for two cycles |
| result_o | output | 8 | Result in the execute phase, PC in the PC phase |

## Verification
In the execute phase, the result path and the commit path act on the same instruction. The bus shows a load, store or branch outcome that is computed from state which the following edge will then change. Stores followed at once by loads to an aliased address, and registers read in the same slot they are overwritten, provoke this. A long run of pseudo-random instructions also provokes it. On every cycle a behavioural reference model judges both the shown result and the PC that follows it.

// File: rtl/duophase_core.sv
module duophase_core #(
  parameter int MEM_AW = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] instr,
  output logic [7:0]  result_o
);
  localparam int MEM_DEPTH = 1 << MEM_AW;

  logic       ph;
  logic [7:0] pc;
  logic [7:0] rf [8];
  logic [7:0] dm [MEM_DEPTH];

  wire [3:0] op  = instr[15:12];
  wire [2:0] rd  = instr[11:9];
  wire [7:0] a   = rf[instr[8:6]];
  wire [7:0] b   = rf[instr[5:3]];
  wire [7:0] imm_i = {{2{instr[5]}}, instr[5:0]};
  wire [7:0] imm_s = {{2{instr[11]}}, instr[11:9], instr[2:0]};
  wire [7:0] ld_addr = a + imm_i;
  wire [7:0] st_addr = a + imm_s;
  wire       idle = (op == 4'hD) || (op == 4'hE) || (op == 4'hF);

  logic [2:0] fsel;
  logic [7:0] alu_b, alu_y, npc, res;
  logic       taken, wr_rd;

  always_comb begin
    alu_b = (op == 4'h0) ? b : imm_i;
    case (op)
      4'h8:    fsel = 3'd2;
      4'h9:    fsel = 3'd3;
      4'hA:    fsel = 3'd4;
      4'hB:    fsel = 3'd5;
      4'hC:    fsel = 3'd6;
      4'h0:    fsel = instr[2:0];
      default: fsel = 3'd0;
    endcase
    case (fsel)
      3'd1:    alu_y = a - alu_b;
      3'd2:    alu_y = a & alu_b;
      3'd3:    alu_y = a | alu_b;
      3'd4:    alu_y = a ^ alu_b;
      3'd5:    alu_y = a << alu_b[2:0];
      3'd6:    alu_y = a >> alu_b[2:0];
      default: alu_y = a + alu_b;
    endcase
  end

  always_comb begin
    case (op)
      4'h5:    taken = (a == b);
      4'h6:    taken = (a != b);
      4'h7:    taken = $signed(a) < $signed(b);
      default: taken = 1'b0;
    endcase
    npc = idle ? pc : (taken ? pc + imm_s : pc + 8'd1);
  end

  always_comb begin
    wr_rd = 1'b0;
    case (op)
      4'h0, 4'h1, 4'h8, 4'h9, 4'hA, 4'hB, 4'hC: begin res = alu_y; wr_rd = 1'b1; end
      4'h2:              begin res = instr[7:0]; wr_rd = 1'b1; end
      4'h3:              begin res = dm[ld_addr[MEM_AW-1:0]]; wr_rd = 1'b1; end
      4'h4:              res = b;
      4'h5, 4'h6, 4'h7:  res = npc;
      default:           res = pc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= 1'b0;
      pc <= '0;
      for (int i = 0; i < 8; i++) rf[i] <= '0;
      for (int j = 0; j < MEM_DEPTH; j++) dm[j] <= '0;
    end else begin
      ph <= ~ph;
      if (ph) begin
        pc <= npc;
        if (wr_rd) rf[rd] <= res;
        if (op == 4'h4) dm[st_addr[MEM_AW-1:0]] <= b;
      end
    end
  end

  assign result_o = ph ? res : pc;
endmodule

// File: rtl/duophase_core_chk.sv
module duophase_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] instr,
  input logic [7:0]  result_o,
  input logic        ph,
  input logic [7:0]  pc
);
  wire [3:0] op     = instr[15:12];
  wire       idle   = (op == 4'hD) || (op == 4'hE) || (op == 4'hF);
  wire       branch = (op == 4'h5) || (op == 4'h6) || (op == 4'h7);

  AST_PHASE_TO_PC:   assert property (@(posedge clk) disable iff (!rst_n) ph |=> !ph); // R2
  AST_PHASE_TO_EXEC: assert property (@(posedge clk) disable iff (!rst_n) !ph |=> ph); // R2
  AST_PC_SHOWN:      assert property (@(posedge clk) disable iff (!rst_n) !ph |-> result_o == pc); // R2
  AST_PC_STILL:      assert property (@(posedge clk) disable iff (!rst_n) !ph |=> pc == $past(pc)); // R8
  AST_PC_STEP:       assert property (@(posedge clk) disable iff (!rst_n)
                       (ph && !idle && !branch) |=> pc == $past(pc) + 8'd1); // R8
  AST_IDLE_HOLD:     assert property (@(posedge clk) disable iff (!rst_n)
                       (ph && idle) |=> pc == $past(pc)); // R9
endmodule

bind duophase_core duophase_core_chk chk_i (
  .clk(clk), .rst_n(rst_n), .instr(instr), .result_o(result_o), .ph(ph), .pc(pc)
);

// File: tb/duophase_core_tb.sv
module duophase_core_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] instr = 16'hF000;
  logic [7:0]  result_o;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  logic [7:0] m_rf [8];
  logic [7:0] m_dm [16];
  logic [7:0] m_pc;

  duophase_core dut_i (.clk(clk), .rst_n(rst_n), .instr(instr), .result_o(result_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input string what, input logic [7:0] got, input logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic logic [7:0] sx(input logic [5:0] v);
    return {{2{v[5]}}, v};
  endfunction

  function automatic logic [7:0] alu(input int f, input logic [7:0] x, input logic [7:0] y);
    case (f)
      1: return x - y;
      2: return x & y;
      3: return x | y;
      4: return x ^ y;
      5: return x << y[2:0];
      6: return x >> y[2:0];
      default: return x + y;
    endcase
  endfunction

  function automatic logic [15:0] rt(input int d, input int s1, input int s2, input int f);
    return 16'((d << 9) | (s1 << 6) | (s2 << 3) | f);
  endfunction
  function automatic logic [15:0] it(input int o, input int d, input int s1, input int k);
    return 16'((o << 12) | (d << 9) | (s1 << 6) | (k & 63));
  endfunction
  function automatic logic [15:0] st(input int o, input int s1, input int s2, input int k);
    return 16'((o << 12) | (((k >> 3) & 7) << 9) | (s1 << 6) | (s2 << 3) | (k & 7));
  endfunction
  function automatic logic [15:0] li(input int d, input int v);
    return 16'((2 << 12) | (d << 9) | (v & 255));
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 8; i++) m_rf[i] = 8'h00;
    for (int i = 0; i < 16; i++) m_dm[i] = 8'h00;
    m_pc = 8'h00;
  endtask

  // Evaluate one instruction against the model; commit when asked.
  task automatic model(input logic [15:0] i, input bit commit, output logic [7:0] res);
    int o = i[15:12];
    logic [7:0] x = m_rf[i[8:6]];
    logic [7:0] y = m_rf[i[5:3]];
    logic [7:0] ki = sx(i[5:0]);
    logic [7:0] ks = sx({i[11:9], i[2:0]});
    logic [7:0] np = m_pc + 8'd1;
    bit wr = 0;
    res = m_pc;
    case (o)
      0:  begin res = alu(int'(i[2:0]), x, y); wr = 1; end
      1:  begin res = x + ki; wr = 1; end
      2:  begin res = i[7:0]; wr = 1; end
      3:  begin res = m_dm[(x + ki) % 16]; wr = 1; end
      4:  res = y;
      5, 6, 7: begin
        bit tk = (o == 5) ? (x == y) : (o == 6) ? (x != y) : ($signed(x) < $signed(y));
        if (tk) np = m_pc + ks;
        res = np;
      end
      8:  begin res = x & ki; wr = 1; end
      9:  begin res = x | ki; wr = 1; end
      10: begin res = x ^ ki; wr = 1; end
      11: begin res = x << ki[2:0]; wr = 1; end
      12: begin res = x >> ki[2:0]; wr = 1; end
      default: np = m_pc;
    endcase
    if (commit) begin
      if (wr) m_rf[i[11:9]] = res;
      if (o == 4) m_dm[(x + ks) % 16] = y;
      m_pc = np;
    end
  endtask

  task automatic slot(input logic [15:0] i, input string tag);
    logic [7:0] r;
    instr = i;
    @(negedge clk);
    model(i, 0, r);
    check(tag, "result", result_o, r);
    model(i, 1, r);
    @(negedge clk);
    check(tag, "pc", result_o, m_pc);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    check("R1", "post-reset output", result_o, 8'h00);
  endtask

  initial begin
    logic [31:0] seed = 32'h1234ABCD;
    do_reset();
    slot(li(1, 4), "R5");
    slot(it(1, 4, 1, 3), "R4");
    slot(it(1, 5, 4, 2), "R8");
    slot(rt(6, 4, 5, 0), "R3");
    slot(rt(2, 5, 4, 1), "R3");
    slot(rt(2, 4, 5, 2), "R3");
    slot(rt(2, 4, 5, 3), "R3");
    slot(rt(2, 4, 5, 4), "R3");
    slot(rt(2, 5, 1, 5), "R3");
    slot(rt(2, 5, 1, 6), "R3");
    slot(rt(2, 4, 5, 7), "R3");
    slot(li(0, 8'h55), "R10");
    slot(rt(2, 0, 0, 0), "R10");
    slot(li(6, 42), "R5");
    slot(it(1, 7, 6, -1), "R4");
    slot(it(8, 3, 6, 6'h0F), "R4");
    slot(it(9, 3, 6, 6'h30), "R4");
    slot(it(10, 3, 6, 6'h3F), "R4");
    slot(it(11, 3, 6, 3), "R4");
    slot(it(12, 3, 6, 2), "R4");
    slot(li(4, 16), "R5");
    slot(st(4, 4, 1, 8), "R6");
    slot(it(3, 6, 4, 8), "R6");
    slot(li(3, 8'hF0), "R5");
    slot(it(3, 2, 3, 8), "R6");
    slot(st(4, 3, 7, -3), "R6");
    slot(it(3, 2, 4, -3), "R6");
    slot(st(5, 1, 1, 4), "R7");
    slot(st(6, 1, 1, 4), "R7");
    slot(li(2, 8'h80), "R5");
    slot(li(3, 1), "R5");
    slot(st(7, 2, 3, 6), "R7");
    slot(st(7, 3, 2, 6), "R7");
    slot(st(6, 2, 3, -32), "R7");
    slot(st(5, 2, 3, -32), "R7");
    slot(16'hF000, "R9");
    slot(16'hD123, "R9");
    slot(16'hE0FF, "R9");
    slot(rt(2, 1, 7, 0), "R9");
    slot(it(3, 2, 4, 8), "R9");
    slot(st(4, 4, 1, 1), "R6");
    do_reset();
    slot(it(3, 2, 4, 1), "R1");
    slot(rt(2, 1, 0, 3), "R1");
    for (int n = 0; n < 600; n++) begin
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 17);
      seed = seed ^ (seed << 5);
      slot(seed[15:0], "R2");
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule